// File: doc/BRIEF.md
# Programmable-Increment Time Counter

This block keeps a free-running 64-bit time value that grows by a programmable fixed-point step once every programmable number of base clock cycles. Software chooses both the step size and the spacing between steps through a single 32-bit control word. Nudging the step slightly above or below its nominal value makes the clock run a little fast or slow. A servo disciplining a precision time clock uses this to steer the counter's rate without ever stepping it backwards.

Software reaches the block through a small register port with a write strobe, a read strobe, a 2-bit register select and 32-bit data. Three registers are defined: the control word, the low time word and the high time word. Both halves of the time value can be read and written. A read of the low word latches all 64 bits, so a later high read returns the matching upper half. A write of the low word is parked in a holding register, and the high write commits both halves in one cycle.

Out of reset the block runs at its nominal rate: the period field holds `RST_PERIOD` and the step is 16 ns in a format with 5 integer and 19 fraction bits (0x800000). With the default 250 MHz base clock and a period of 4, one 16 ns step is taken every 16 ns.

Top module: `ptc_counter`

## Requirements
- R1: After synchronous reset, the control word reads back as `{RST_PERIOD, RST_INC}` (defaults 0x04800000), the time value is zero and `rd_valid` is low.
- R2: Control word layout (register select 0): bits 31:24 are the period field and bits 23:0 are the increment; a write is read back unchanged.
- R3: When the period field P is non-zero, the time value grows by the 24-bit increment, zero-extended, once every P base clock cycles, and wraps modulo 2^64.
- R4: A period field of 0 stops all increments; the time value holds until it is written or a non-zero period is programmed.
- R5: A control word write restarts the period count. The first increment using the new word is applied P cycles after the write edge. A step due on the write edge itself still uses the old word.
- R6: A read of the low time word (select 1) returns bits 31:0 of the time value before that clock edge, and at the same edge it latches all 64 bits. A later read of the high word (select 2) returns bits 63:32 of that same latched value, even if the counter has advanced in between.
- R7: A high word read with no low word read before it returns the upper half of the most recent latch (zero if none since reset), and repeated high reads return the same value.
- R8: A low word write (select 1) only fills a holding register and leaves the time value untouched. A high word write (select 2) loads the time value with `{high data, held low data}`.
- R9: When a high word write and a due increment fall on the same edge, the written value is loaded and the increment is dropped.
- R10: Read data and `rd_valid` are registered. The cycle after `rd_en` is high, `rd_valid` is high; otherwise it is low. Select 3 reads as zero, and reads never change the time value or the control word.
- R11: With reset defaults, the time value advances by 0x800000 (16 ns in the 19-fraction-bit format) every 4 base cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 control, 1 time low, 2 time high, 3 unused |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | High the cycle after a read strobe |

## Verification
The counter is driven at the nominal rate, at a short period with an odd increment, at period 1 (a step every cycle) and with the period set to zero. These separate divider errors from step-size errors and show whether a disabled counter really holds. The latched-read checks set the time just below a 32-bit carry and read low, then high, a few cycles apart. Only a true 64-bit latch returns a consistent pair there. The split-write checks read between the two halves, and they write the high half at period 1. That tells apart a design that commits early and one that lets a simultaneous step win over the load.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int DATA_W = 32;
  localparam int TIME_W = 2 * DATA_W;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_TLO  = 2'd1,
    SEL_THI  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ptc_divider.sv
module ptc_divider #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period,
  input  logic             restart,
  output logic             tick,
  output logic [PER_W-1:0] cnt
);
  logic per_zero;

  always_comb begin
    per_zero = (period == '0);
    tick     = !per_zero && (cnt == period - PER_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (tick || per_zero) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + PER_W'(1);
    end
  end
endmodule

// File: rtl/ptc_accum.sv
module ptc_accum #(
  parameter int TIME_W = 64,
  parameter int INC_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [INC_W-1:0]  inc,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  output logic [TIME_W-1:0] time_q
);
  logic [TIME_W-1:0] step;

  always_comb step = {{(TIME_W-INC_W){1'b0}}, inc};

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q <= '0;
    end else if (load) begin
      time_q <= load_val;
    end else if (tick) begin
      time_q <= time_q + step;
    end
  end
endmodule

// File: rtl/ptc_regs.sv
module ptc_regs
  import ptc_pkg::*;
#(
  parameter int                 PER_W      = 8,
  parameter int                 INC_W      = 24,
  parameter logic [PER_W-1:0]   RST_PERIOD = 8'd4,
  parameter logic [INC_W-1:0]   RST_INC    = 24'h800000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TIME_W-1:0] time_q,
  output logic [PER_W-1:0]  per_q,
  output logic [INC_W-1:0]  inc_q,
  output logic              ctrl_wr,
  output logic              time_ld,
  output logic [TIME_W-1:0] time_ld_val,
  output logic [DATA_W-1:0] held_lo,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  reg_sel_e          sel;
  logic [TIME_W-1:0] rd_latch;

  always_comb begin
    sel         = reg_sel_e'(addr);
    ctrl_wr     = wr_en && (sel == SEL_CTRL);
    time_ld     = wr_en && (sel == SEL_THI);
    time_ld_val = {wdata, held_lo};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= RST_PERIOD;
      inc_q <= RST_INC;
    end else if (ctrl_wr) begin
      per_q <= wdata[DATA_W-1 -: PER_W];
      inc_q <= wdata[INC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_lo <= '0;
    end else if (wr_en && (sel == SEL_TLO)) begin
      held_lo <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_latch <= '0;
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        unique case (sel)
          SEL_CTRL: rdata <= {per_q, inc_q};
          SEL_TLO: begin
            rdata    <= time_q[DATA_W-1:0];
            rd_latch <= time_q;
          end
          SEL_THI:  rdata <= rd_latch[TIME_W-1:DATA_W];
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ptc_counter.sv
module ptc_counter
  import ptc_pkg::*;
#(
  parameter int                 PER_W      = 8,
  parameter int                 INC_W      = 24,
  parameter logic [PER_W-1:0]   RST_PERIOD = 8'd4,
  parameter logic [INC_W-1:0]   RST_INC    = 24'h800000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  logic [PER_W-1:0]  per_q;
  logic [INC_W-1:0]  inc_q;
  logic              ctrl_wr;
  logic              time_ld;
  logic [TIME_W-1:0] time_ld_val;
  logic [DATA_W-1:0] held_lo;
  logic [TIME_W-1:0] time_q;
  logic              tick;
  logic [PER_W-1:0]  div_cnt;

  ptc_regs #(
    .PER_W(PER_W), .INC_W(INC_W), .RST_PERIOD(RST_PERIOD), .RST_INC(RST_INC)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .time_q(time_q), .per_q(per_q), .inc_q(inc_q),
    .ctrl_wr(ctrl_wr), .time_ld(time_ld), .time_ld_val(time_ld_val),
    .held_lo(held_lo), .rdata(rdata), .rd_valid(rd_valid)
  );

  ptc_divider #(.PER_W(PER_W)) u_div (
    .clk(clk), .rst(rst), .period(per_q), .restart(ctrl_wr),
    .tick(tick), .cnt(div_cnt)
  );

  ptc_accum #(.TIME_W(TIME_W), .INC_W(INC_W)) u_acc (
    .clk(clk), .rst(rst), .tick(tick), .inc(inc_q), .load(time_ld),
    .load_val(time_ld_val), .time_q(time_q)
  );
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker
  import ptc_pkg::*;
#(
  parameter int PER_W = 8,
  parameter int INC_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              rd_valid,
  input logic [TIME_W-1:0] time_q,
  input logic [PER_W-1:0]  per_q,
  input logic [INC_W-1:0]  inc_q,
  input logic              tick,
  input logic [PER_W-1:0]  div_cnt,
  input logic [DATA_W-1:0] held_lo
);
  // R3
  step_applied_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !(wr_en && addr == 2'd2)) |=>
      time_q == $past(time_q) + {{(TIME_W-INC_W){1'b0}}, $past(inc_q)});

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (per_q == '0 && !(wr_en && addr == 2'd2)) |=> $stable(time_q));

  // R5
  restart_count_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd0) |=> div_cnt == '0);

  // R8
  commit_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd2) |=> time_q == {$past(wdata), $past(held_lo)});

  // R6
  low_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd1) |=> rdata == $past(time_q[DATA_W-1:0]));

  // R10
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R10
  valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

bind ptc_counter ptc_checker #(.PER_W(PER_W), .INC_W(INC_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .time_q(time_q),
  .per_q(per_q), .inc_q(inc_q), .tick(tick), .div_cnt(div_cnt),
  .held_lo(held_lo)
);

// File: tb/ptc_counter_tb.sv
`timescale 1ns/1ps
module ptc_counter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        rd_valid;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  ptc_counter u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
  );

  // behavioural reference
  int          m_per;
  int          m_cnt;
  logic [23:0] m_inc;
  logic [63:0] m_time;
  logic [63:0] m_latch;
  logic [31:0] m_held;
  logic [31:0] exp_rdata;
  logic        exp_valid;

  always @(posedge clk) begin
    bit due;
    if (rst) begin
      m_per = 4; m_inc = 24'h800000; m_cnt = 0; m_time = '0;
      m_latch = '0; m_held = '0; exp_valid = 1'b0; exp_rdata = '0;
    end else begin
      due = (m_per != 0) && (m_cnt == m_per - 1);
      exp_valid = rd_en;
      if (rd_en) begin
        case (addr)
          2'd0: exp_rdata = {m_per[7:0], m_inc};
          2'd1: begin m_latch = m_time; exp_rdata = m_time[31:0]; end
          2'd2: exp_rdata = m_latch[63:32];
          default: exp_rdata = 32'd0;
        endcase
      end
      if (wr_en && addr == 2'd2) m_time = {wdata, m_held};
      else if (due) m_time = m_time + {40'd0, m_inc};
      if (wr_en && addr == 2'd1) m_held = wdata;
      if (wr_en && addr == 2'd0) begin
        m_per = int'(wdata[31:24]); m_inc = wdata[23:0]; m_cnt = 0;
      end else if (due || m_per == 0) m_cnt = 0;
      else m_cnt = m_cnt + 1;
    end
  end

  // compared every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_checks++;
      if (rd_valid !== exp_valid) begin
        n_fail++;
        $display("FAIL %s rd_valid actual=%0b expected=%0b", cur_req, rd_valid, exp_valid);
      end else if (exp_valid && rdata !== exp_rdata) begin
        n_fail++;
        $display("FAIL %s rdata actual=%h expected=%h", cur_req, rdata, exp_rdata);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic summary;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    idle(4);
    rst = 1'b0;
    // R1 reset state
    cur_req = "R1"; rd(2'd0); rd(2'd2); rd(2'd1); idle(1);
    // R11 nominal rate, R3 periodic step
    cur_req = "R11"; idle(17); rd(2'd1); rd(2'd2); idle(5); rd(2'd1); idle(2);
    // R2 control layout
    cur_req = "R2"; wr(2'd0, 32'h03_000123); rd(2'd0); idle(1);
    // R3 short period, odd step
    cur_req = "R3"; for (int i = 0; i < 6; i++) begin rd(2'd1); idle(i); end
    // R5 restart on control write
    cur_req = "R5";
    wr(2'd0, 32'h05_000011); rd(2'd1); rd(2'd1); rd(2'd1); rd(2'd1); rd(2'd1); rd(2'd1);
    idle(2); wr(2'd0, 32'h05_000022); idle(3); rd(2'd1); rd(2'd1);
    // R4 period zero freezes
    cur_req = "R4"; wr(2'd0, 32'h00_0fffff); rd(2'd1); idle(20); rd(2'd1); rd(2'd2);
    // R8 split write
    cur_req = "R8"; wr(2'd1, 32'hfffffff0); rd(2'd1); rd(2'd2); wr(2'd2, 32'h00000005);
    rd(2'd1); rd(2'd2);
    // R6 latched read across a low-word carry
    cur_req = "R6"; wr(2'd0, 32'h01_000004); rd(2'd1); idle(3); rd(2'd2);
    rd(2'd1); idle(1); rd(2'd1); idle(6); rd(2'd2);
    // R7 high read without a fresh low read
    cur_req = "R7"; rd(2'd2); idle(4); rd(2'd2); rd(2'd2);
    // R9 load beats a step on the same edge (period 1 steps every cycle)
    cur_req = "R9"; wr(2'd1, 32'h12345678); wr(2'd2, 32'h0000abcd); rd(2'd1); rd(2'd2);
    wr(2'd2, 32'h00000001); rd(2'd1);
    // R10 unused select, reads disturb nothing
    cur_req = "R10"; rd(2'd3); rd(2'd0); rd(2'd3); idle(2); rd(2'd0);
    // R3 wrap modulo 2^64
    cur_req = "R3"; wr(2'd1, 32'hfffffffe); wr(2'd0, 32'h00_000000);
    wr(2'd2, 32'hffffffff); wr(2'd0, 32'h01_000003); rd(2'd1); rd(2'd2); idle(1);
    rd(2'd1); rd(2'd2);
    idle(2);
    summary();
  end
endmodule